// File: doc/BRIEF.md
# Converter Fault Supervisor

This block is the protection sequencer of a resonant power converter. It receives digitized comparator flags and decides, clock by clock, whether the pulse generator may switch. The flags are: a fast fault, a slow fault, a feedback fault, brownout-ok, a latch request, over-temperature, and two supply levels (turn-on and minimum operating). The block also tells the pulse generator when a restart must begin with a soft-start ramp.

Slow faults and feedback faults are integrated in a 12-bit fault timer. The timer does not clear when the fault goes away. It charges at a programmable rate and decays at a separate, slower programmable rate. When it reaches a stop level, pulses halt and charging is blocked. Pulses come back, with soft-start, only after the timer has decayed to a lower restart level. A fault that persists therefore produces hiccup retries.

The fast fault blanks pulses for as long as it is held. A static select input chooses between two recovery policies for fast-fault release. Policy A resumes without soft-start, so that skip-cycle operation works, unless a feedback fault was seen during the hold. Policy B always soft-starts. A latch request that is held long enough shuts the converter off until reset.

Top module: `fault_supervisor`

## Requirements
- R1: Pulses need a supply qualification. This qualification is set once the turn-on flag is seen and cleared when the minimum-level flag drops. The minimum-level flag alone never qualifies. The first start after qualification raises ss_req_o. status_o bit 5 is high while the supply is not qualified.
- R2: While brownout-ok is low, pulses are off and status_o bit 3 is high. On recovery, pulses resume with ss_req_o.
- R3: While over-temperature is high, pulses are off and status_o bit 4 is high. On recovery, pulses resume with ss_req_o.
- R4: A fast fault drives pulse_en_o low no later than the third rising edge after it is applied. Pulses stay off while it is held, and status_o bit 2 shows the hold.
- R5: With variant_b_i low, releasing a fast fault resumes pulses without ss_req_o, provided no feedback fault was seen during the hold.
- R6: With variant_b_i low, a feedback fault seen during a fast-fault hold makes the release raise ss_req_o. With variant_b_i high, every fast-fault release raises ss_req_o.
- R7: While a slow fault or a feedback fault is present, the timer gains one count every chg_div_i+1 cycles. When the timer reaches STOP_LVL (3276 by default), pulses stop and status_o bit 1 goes high. status_o bit 6 is high while the timer is charging.
- R8: The timer is not cleared when the faults go away. With no fault present, it loses one count every dec_div_i+1 cycles, so earlier fault time adds to later fault time.
- R9: After a stop, the timer decays to RESTART_LVL (819 by default) and pulses then resume with ss_req_o. If the restart point is passed while a fast fault is held, the soft-start request is kept until the pulses actually resume.
- R10: A latch request held for LATCH_CYC consecutive cycles turns pulses off and sets status_o bit 0. Both stay that way until rst_ni. A shorter request has no effect.
- R11: ss_req_o lasts one cycle and occurs only in the cycle in which pulse_en_o rises.
- R12: While rst_ni is low, pulse_en_o, ss_req_o and status_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low (supply reset) |
| variant_b_i | input | 1 | static policy select: 0 = A, 1 = B |
| fast_flt_i | input | 1 | fast fault comparator flag |
| slow_flt_i | input | 1 | slow fault comparator flag |
| fb_flt_i | input | 1 | feedback-low fault flag |
| bo_ok_i | input | 1 | brownout-ok flag |
| latch_req_i | input | 1 | permanent shutdown request flag |
| otemp_i | input | 1 | over-temperature flag |
| vcc_on_i | input | 1 | supply above turn-on level |
| vcc_min_i | input | 1 | supply above minimum operating level |
| chg_div_i | input | DIV_W | charge prescaler, one count per value+1 cycles |
| dec_div_i | input | DIV_W | decay prescaler, one count per value+1 cycles |
| pulse_en_o | output | 1 | pulses allowed |
| ss_req_o | output | 1 | soft-start request, one cycle |
| status_o | output | 7 | registered status, bits as listed in the requirements |

## Verification
The overlap of interest is between timer recovery and a fast-fault hold. The bench trips the timer with a slow fault, then asserts the fast fault and holds it for longer than the whole decay, so the restart level is crossed while the fast fault still blanks pulses. At the end of the hold, the bench checks that the stop status has cleared and that pulse_en_o is still low. It then checks that the fast-fault release produces a pulse rise accompanied by ss_req_o, even though policy A alone would give no soft-start. The scoreboard compares the ordered stream of rise, rise-with-soft-start and fall events against the sequence predicted from the requirements.

// File: rtl/fsv_pkg.sv
package fsv_pkg;
  localparam int NFLAG = 8;
  localparam int F_FAST = 0;
  localparam int F_SLOW = 1;
  localparam int F_FB   = 2;
  localparam int F_BO   = 3;
  localparam int F_LAT  = 4;
  localparam int F_OT   = 5;
  localparam int F_VON  = 6;
  localparam int F_VMIN = 7;

  // bit 6 down to bit 0
  typedef struct packed {
    logic charging;
    logic supply_low;
    logic over_temp;
    logic bo_low;
    logic fast_hold;
    logic tmr_stop;
    logic latched;
  } status_t;

  localparam int STATUS_W = $bits(status_t);
endpackage

// File: rtl/fsv_sync.sv
module fsv_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= d_i[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fsv_latch_filt.sv
module fsv_latch_filt #(
  parameter int LATCH_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic latched_o
);
  localparam int CW = $clog2(LATCH_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LATCH_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          latched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      latched_q <= 1'b0;
    end else begin
      if (!req_i)             cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      // sticky until reset
      if (req_i && cnt_q == LAST) latched_q <= 1'b1;
    end
  end

  assign latched_o = latched_q;
endmodule

// File: rtl/fsv_fault_timer.sv
module fsv_fault_timer #(
  parameter int TMR_W       = 12,
  parameter int DIV_W       = 8,
  parameter int STOP_LVL    = 3276,
  parameter int RESTART_LVL = 819
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic [DIV_W-1:0] chg_div_i,
  input  logic [DIV_W-1:0] dec_div_i,
  output logic             stop_o,
  output logic             charging_o
);
  localparam logic [TMR_W-1:0] STOP_V    = TMR_W'(STOP_LVL);
  localparam logic [TMR_W-1:0] RESTART_V = TMR_W'(RESTART_LVL);
  localparam logic [TMR_W-1:0] FULL_V    = '1;

  logic [TMR_W-1:0] level_q;
  logic [DIV_W-1:0] pre_q;
  logic             dir_q;
  logic             stop_q;
  logic             charge;
  logic [DIV_W-1:0] div_sel;
  logic             tick;

  assign charge  = fault_i & ~stop_q;
  assign div_sel = charge ? chg_div_i : dec_div_i;
  // prescaler restarts whenever the direction flips
  assign tick    = (charge == dir_q) && (pre_q >= div_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b0;
      pre_q <= '0;
    end else begin
      dir_q <= charge;
      if (charge != dir_q || tick) pre_q <= '0;
      else                         pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
    end else if (tick) begin
      if (charge && level_q != FULL_V)     level_q <= level_q + 1'b1;
      else if (!charge && level_q != '0)   level_q <= level_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              stop_q <= 1'b0;
    else if (!stop_q && level_q >= STOP_V)    stop_q <= 1'b1;
    else if (stop_q && level_q <= RESTART_V)  stop_q <= 1'b0;
  end

  assign stop_o     = stop_q;
  assign charging_o = charge;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsv_pkg::*;
#(
  parameter int TMR_W       = 12,
  parameter int DIV_W       = 8,
  parameter int STOP_LVL    = ((2 ** TMR_W) * 4) / 5,
  parameter int RESTART_LVL = (2 ** TMR_W) / 5,
  parameter int LATCH_CYC   = 2500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             variant_b_i,
  input  logic             fast_flt_i,
  input  logic             slow_flt_i,
  input  logic             fb_flt_i,
  input  logic             bo_ok_i,
  input  logic             latch_req_i,
  input  logic             otemp_i,
  input  logic             vcc_on_i,
  input  logic             vcc_min_i,
  input  logic [DIV_W-1:0] chg_div_i,
  input  logic [DIV_W-1:0] dec_div_i,
  output logic             pulse_en_o,
  output logic             ss_req_o,
  output logic [6:0]       status_o
);
  logic [NFLAG-1:0] raw, flg;
  logic             latched, tmr_stop, charging;
  logic             vcc_ok_q, pulse_en_q, ss_req_q, ss_pend_q;
  logic             run_ok, ss_set;
  status_t          status_q;

  assign raw[F_FAST] = fast_flt_i;
  assign raw[F_SLOW] = slow_flt_i;
  assign raw[F_FB]   = fb_flt_i;
  assign raw[F_BO]   = bo_ok_i;
  assign raw[F_LAT]  = latch_req_i;
  assign raw[F_OT]   = otemp_i;
  assign raw[F_VON]  = vcc_on_i;
  assign raw[F_VMIN] = vcc_min_i;

  fsv_sync #(.W(NFLAG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (flg)
  );

  fsv_latch_filt #(.LATCH_CYC(LATCH_CYC)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (flg[F_LAT]),
    .latched_o(latched)
  );

  fsv_fault_timer #(
    .TMR_W      (TMR_W),
    .DIV_W      (DIV_W),
    .STOP_LVL   (STOP_LVL),
    .RESTART_LVL(RESTART_LVL)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (flg[F_SLOW] | flg[F_FB]),
    .chg_div_i (chg_div_i),
    .dec_div_i (dec_div_i),
    .stop_o    (tmr_stop),
    .charging_o(charging)
  );

  // supply hysteresis: qualify on turn-on, drop below minimum
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             vcc_ok_q <= 1'b0;
    else if (!flg[F_VMIN])   vcc_ok_q <= 1'b0;
    else if (flg[F_VON])     vcc_ok_q <= 1'b1;
  end

  assign run_ok = vcc_ok_q & flg[F_BO] & ~flg[F_OT] & ~latched
                & ~tmr_stop & ~flg[F_FAST];

  // any cause that needs a soft restart arms the pending flag
  assign ss_set = ~vcc_ok_q | ~flg[F_BO] | flg[F_OT] | tmr_stop
                | (flg[F_FAST] & (variant_b_i | flg[F_FB]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_pend_q  <= 1'b1;
      pulse_en_q <= 1'b0;
      ss_req_q   <= 1'b0;
    end else begin
      pulse_en_q <= run_ok;
      ss_req_q   <= run_ok & ~pulse_en_q & ss_pend_q;
      if (run_ok && !pulse_en_q) ss_pend_q <= 1'b0;
      else if (ss_set)           ss_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else begin
      status_q.charging   <= charging;
      status_q.supply_low <= ~vcc_ok_q;
      status_q.over_temp  <= flg[F_OT];
      status_q.bo_low     <= ~flg[F_BO];
      status_q.fast_hold  <= flg[F_FAST];
      status_q.tmr_stop   <= tmr_stop;
      status_q.latched    <= latched;
    end
  end

  assign pulse_en_o = pulse_en_q;
  assign ss_req_o   = ss_req_q;
  assign status_o   = status_q;
endmodule

// File: rtl/fsv_checker.sv
module fsv_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pulse_en_o,
  input logic       ss_req_o,
  input logic [6:0] status_o
);
  assert_supply_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] |-> !pulse_en_o);
  assert_bo_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] |-> !pulse_en_o);
  assert_ot_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4] |-> !pulse_en_o);
  assert_fast_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> !pulse_en_o);
  assert_stop_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] |-> !pulse_en_o);
  assert_latch_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> !pulse_en_o);
  assert_latch_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |=> status_o[0]);
  assert_ss_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_req_o |=> !ss_req_o);
  assert_ss_on_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_req_o |-> (pulse_en_o && !$past(pulse_en_o)));
endmodule

bind fault_supervisor fsv_checker u_fsv_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pulse_en_o(pulse_en_o),
  .ss_req_o  (ss_req_o),
  .status_o  (status_o)
);

// File: tb/tb_fault_supervisor.sv
module tb_fault_supervisor;
  localparam int DIV_W = 8;
  localparam int EV_NONE = 0, EV_ON = 1, EV_ON_SS = 2, EV_OFF = 3, EV_SS_STRAY = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic variant_b_i = 1'b0, fast_flt_i = 1'b0, slow_flt_i = 1'b0, fb_flt_i = 1'b0;
  logic bo_ok_i = 1'b1, latch_req_i = 1'b0, otemp_i = 1'b0;
  logic vcc_on_i = 1'b0, vcc_min_i = 1'b1;
  logic [DIV_W-1:0] chg_div_i = '0, dec_div_i = 8'd255;
  logic pulse_en_o, ss_req_o;
  logic [6:0] status_o;

  int n_chk = 0, n_err = 0;
  int exp_q[$];
  logic prev_p = 1'b0;

  always #4 clk_i = ~clk_i;

  fault_supervisor dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .variant_b_i(variant_b_i),
    .fast_flt_i(fast_flt_i), .slow_flt_i(slow_flt_i), .fb_flt_i(fb_flt_i),
    .bo_ok_i(bo_ok_i), .latch_req_i(latch_req_i), .otemp_i(otemp_i),
    .vcc_on_i(vcc_on_i), .vcc_min_i(vcc_min_i),
    .chg_div_i(chg_div_i), .dec_div_i(dec_div_i),
    .pulse_en_o(pulse_en_o), .ss_req_o(ss_req_o), .status_o(status_o)
  );

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic expect_ev(input int ev);
    exp_q.push_back(ev);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_pulse(input string req, input logic v, input int max_cyc);
    int n = 0;
    while (pulse_en_o !== v && n < max_cyc) begin
      @(negedge clk_i);
      n++;
    end
    chk(req, "pulse_en level reached", int'(pulse_en_o), int'(v));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cyc(3);
    chk("R12", "pulse_en in reset", int'(pulse_en_o), 0);
    chk("R12", "ss_req in reset", int'(ss_req_o), 0);
    chk("R12", "status in reset", int'(status_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic power_up();
    expect_ev(EV_ON_SS);
    vcc_on_i = 1'b1;
    cyc(4);
    vcc_on_i = 1'b0;
    wait_pulse("R1", 1'b1, 20);
  endtask

  // monitor: turns output edges into events and scores them
  initial begin
    forever begin
      int ev;
      @(negedge clk_i);
      ev = EV_NONE;
      if (pulse_en_o && !prev_p)      ev = ss_req_o ? EV_ON_SS : EV_ON;
      else if (!pulse_en_o && prev_p) ev = EV_OFF;
      else if (ss_req_o)              ev = EV_SS_STRAY;
      prev_p = pulse_en_o;
      if (ev != EV_NONE) begin
        if (exp_q.size() == 0) chk("R11", "unexpected event", ev, EV_NONE);
        else begin
          int e;
          e = exp_q.pop_front();
          chk("R11", "event order", ev, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R12: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    // R1: minimum level alone does not qualify
    cyc(20);
    chk("R1", "no pulse without turn-on", int'(pulse_en_o), 0);
    chk("R1", "supply_low status", int'(status_o[5]), 1);
    power_up();
    cyc(10);
    chk("R1", "supply_low cleared", int'(status_o[5]), 0);

    // R4/R5: fast fault, policy A, no feedback fault
    expect_ev(EV_OFF);
    expect_ev(EV_ON);
    fast_flt_i = 1'b1;
    cyc(3);
    chk("R4", "pulse off within 3 edges", int'(pulse_en_o), 0);
    cyc(30);
    chk("R4", "fast_hold status", int'(status_o[2]), 1);
    chk("R4", "still off while held", int'(pulse_en_o), 0);
    fast_flt_i = 1'b0;
    wait_pulse("R5", 1'b1, 10);
    cyc(10);

    // R6: policy A with feedback fault during hold
    expect_ev(EV_OFF);
    expect_ev(EV_ON_SS);
    fast_flt_i = 1'b1;
    cyc(5);
    fb_flt_i = 1'b1;
    cyc(20);
    fb_flt_i = 1'b0;
    cyc(5);
    fast_flt_i = 1'b0;
    wait_pulse("R6", 1'b1, 10);
    cyc(10);

    // R6: policy B always soft-starts
    variant_b_i = 1'b1;
    expect_ev(EV_OFF);
    expect_ev(EV_ON_SS);
    fast_flt_i = 1'b1;
    cyc(20);
    fast_flt_i = 1'b0;
    wait_pulse("R6", 1'b1, 10);
    variant_b_i = 1'b0;
    cyc(10);

    // R2 brownout
    expect_ev(EV_OFF);
    expect_ev(EV_ON_SS);
    bo_ok_i = 1'b0;
    cyc(10);
    chk("R2", "bo_low status", int'(status_o[3]), 1);
    chk("R2", "pulses off", int'(pulse_en_o), 0);
    bo_ok_i = 1'b1;
    wait_pulse("R2", 1'b1, 10);
    cyc(10);

    // R3 over-temperature
    expect_ev(EV_OFF);
    expect_ev(EV_ON_SS);
    otemp_i = 1'b1;
    cyc(10);
    chk("R3", "over_temp status", int'(status_o[4]), 1);
    otemp_i = 1'b0;
    wait_pulse("R3", 1'b1, 10);
    cyc(10);

    // R1 undervoltage: minimum return alone does not restart
    expect_ev(EV_OFF);
    vcc_min_i = 1'b0;
    cyc(10);
    vcc_min_i = 1'b1;
    cyc(30);
    chk("R1", "no restart without turn-on", int'(pulse_en_o), 0);
    power_up();
    cyc(10);
    chk("R11", "events drained", exp_q.size(), 0);

    // R7/R8: cumulative charge from a clean timer
    expect_ev(EV_OFF);
    do_reset();
    power_up();
    cyc(10);
    chg_div_i = 8'd0;
    dec_div_i = 8'd255;
    slow_flt_i = 1'b1;
    cyc(20);
    chk("R7", "charging status", int'(status_o[6]), 1);
    cyc(1980);
    slow_flt_i = 1'b0;
    cyc(100);
    chk("R8", "pulses kept after first fault", int'(pulse_en_o), 1);
    expect_ev(EV_OFF);
    slow_flt_i = 1'b1;
    cyc(1100);
    chk("R8", "second fault not yet at stop", int'(pulse_en_o), 1);
    wait_pulse("R8", 1'b0, 400);
    chk("R7", "tmr_stop status", int'(status_o[1]), 1);

    // R9: decay to restart level, then soft-start
    dec_div_i = 8'd1;
    slow_flt_i = 1'b0;
    cyc(4500);
    chk("R9", "still stopped during decay", int'(pulse_en_o), 0);
    chk("R9", "stop status during decay", int'(status_o[1]), 1);
    expect_ev(EV_ON_SS);
    wait_pulse("R9", 1'b1, 800);
    cyc(10);

    // R9 overlap: restart level crossed while fast fault held
    expect_ev(EV_OFF);
    slow_flt_i = 1'b1;
    wait_pulse("R7", 1'b0, 3000);
    slow_flt_i = 1'b0;
    fast_flt_i = 1'b1;
    cyc(6000);
    chk("R9", "stop cleared under fast hold", int'(status_o[1]), 0);
    chk("R9", "pulses held by fast fault", int'(pulse_en_o), 0);
    expect_ev(EV_ON_SS);
    fast_flt_i = 1'b0;
    wait_pulse("R9", 1'b1, 10);
    cyc(10);

    // R10: short request ignored, long one latches
    latch_req_i = 1'b1;
    cyc(1000);
    latch_req_i = 1'b0;
    cyc(10);
    chk("R10", "short request ignored", int'(pulse_en_o), 1);
    chk("R10", "latched status after short", int'(status_o[0]), 0);
    expect_ev(EV_OFF);
    latch_req_i = 1'b1;
    cyc(3000);
    latch_req_i = 1'b0;
    cyc(200);
    chk("R10", "latched off", int'(pulse_en_o), 0);
    chk("R10", "latched status", int'(status_o[0]), 1);
    do_reset();
    power_up();
    cyc(10);
    chk("R10", "latch cleared by reset", int'(status_o[0]), 0);
    chk("R11", "events drained at end", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule